// File: doc/BRIEF.md
# Single-cycle byte-coded 32-bit core

This block is a small 32-bit processor core that completes one instruction per clock. Each cycle it presents its program counter on the fetch address port. It receives a six-byte, little-endian window of instruction bytes from a combinational instruction store and splits that window into fields. It reads up to two operands from an eight-entry register file, computes the result and writes it back. In the same cycle it moves the program counter forward by the length of the instruction.

The supported operations are:
- stop
- no-op
- register-to-register move
- conditional register move
- load of a 32-bit immediate into a register
- four ALU operations that also record sign and zero flags

A two-bit status output reports whether the core is running, has stopped on the stop instruction, or has met an illegal encoding. Once the core leaves the running state it freezes. A flat debug view exposes all eight registers so that an external observer can follow execution.

Top module: `bcc_core`

## Requirements
- R1: While reset is asserted and on release, the fetch address is 0, status is 0 (running), and every register reads 0.
- R2: Encoding layout, with byte k of the fetch window at bits [8k+7:8k]. Bits [7:4] hold the opcode and bits [3:0] the function code. Bits [15:12] name operand A and bits [11:8] name operand B. Bytes 2 to 5 hold a little-endian 32-bit immediate. Opcode 3 writes the immediate to register B and adds 6 to the PC. For example, the window 0x0000000af230 writes 10 to register 2.
- R3: Opcode 2 with function 0 copies register A into register B and adds 2 to the PC.
- R4: Opcode 6 writes an ALU result to register B and adds 2 to the PC. The function code selects the operation: 0 gives B+A, 1 gives B−A, 2 gives B AND A, and 3 gives B XOR A.
- R5: An ALU operation records three flags from its 32-bit result taken as signed: less-than-zero, equal-to-zero and greater-than-zero. After reset only the equal flag is set.
- R6: Opcode 2 with function 1 to 6 moves register A into register B only when its condition holds. The conditions are: 1 lt or eq, 2 lt, 3 eq, 4 not eq, 5 gt or eq, 6 gt. When the condition fails, no register changes, and the PC still adds 2.
- R7: Opcode 1 is a one-byte no-op. It adds 1 to the PC and changes no register.
- R8: Opcode 0 sets status to 1 (stopped) and leaves the PC on that instruction. From then on the PC, the registers and the status stay unchanged until reset.
- R9: These encodings are illegal: opcodes 4, 5 and 7 to 15, opcode 2 with function above 6, and opcode 6 with function above 3. An illegal encoding sets status to 2, holds the PC on it, and writes no register. From then on everything stays frozen until reset.
- R10: Register index 0xF reads as 0, and a write aimed at index 0xF is discarded.
- R11: The flags change only on an ALU operation. Moves, immediate loads, no-ops and discarded conditional moves leave them as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Fetch address (the program counter) |
| imem_data | input | 48 | Six instruction bytes at imem_addr, little-endian |
| stat | output | 2 | 0 running, 1 stopped, 2 illegal encoding |
| dbg_regs | output | 256 | All registers; register i at bits [32i+31:32i] |

## Verification
The hardest condition to reach from the ports is a conditional move that meets each of the three flag states for each of its six conditions. The flags are hidden, so the test must first set them through an ALU result of the right sign, including the signed-overflow case where an addition reaches 0x80000000. Random programs draw their immediates from a pool of 0, 1, all-ones, 0x7fffffff, 0x80000000 and random words, and they mix ALU operations with conditional moves. A bench instruction model predicts the PC, the status and all eight registers after every cycle. Directed programs cover the flag state after reset, the discarded index 0xF, and each illegal form.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    localparam int WORD_W      = 32;
    localparam int REG_CNT     = 8;
    localparam int IDX_W       = 4;
    localparam int FETCH_BYTES = 6;
    localparam int FETCH_W     = 8 * FETCH_BYTES;
    localparam int LEN_W       = 3;

    localparam logic [3:0] OP_STOP = 4'h0;
    localparam logic [3:0] OP_NOP  = 4'h1;
    localparam logic [3:0] OP_MOVE = 4'h2;
    localparam logic [3:0] OP_IMM  = 4'h3;
    localparam logic [3:0] OP_ALU  = 4'h6;

    localparam logic [IDX_W-1:0] NO_REG = 4'hF;

    localparam logic [3:0] FN_ADD = 4'h0;
    localparam logic [3:0] FN_SUB = 4'h1;
    localparam logic [3:0] FN_AND = 4'h2;
    localparam logic [3:0] FN_XOR = 4'h3;

    localparam logic [3:0] CC_ALW = 4'h0;
    localparam logic [3:0] CC_LE  = 4'h1;
    localparam logic [3:0] CC_LT  = 4'h2;
    localparam logic [3:0] CC_EQ  = 4'h3;
    localparam logic [3:0] CC_NE  = 4'h4;
    localparam logic [3:0] CC_GE  = 4'h5;
    localparam logic [3:0] CC_GT  = 4'h6;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_ILL  = 2'd2
    } status_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } flags_t;

    typedef struct packed {
        status_e          st;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] dst_e;
        logic [IDX_W-1:0] dst_m;
        logic             set_cc;
        logic             is_cond;
    } ctrl_t;
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
(
    input  logic [FETCH_W-1:0] fetch_word,
    output logic [3:0]         icode,
    output logic [3:0]         ifun,
    output logic [WORD_W-1:0]  imm,
    output ctrl_t              ctl
);
    logic [IDX_W-1:0] opa;
    logic [IDX_W-1:0] opb;

    always_comb begin
        icode = fetch_word[7:4];
        ifun  = fetch_word[3:0];
        opa   = fetch_word[15:12];
        opb   = fetch_word[11:8];
        imm   = fetch_word[FETCH_W-1:16];

        ctl.st      = ST_ILL;
        ctl.len     = '0;
        ctl.src_a   = NO_REG;
        ctl.src_b   = NO_REG;
        ctl.dst_e   = NO_REG;
        ctl.dst_m   = NO_REG;
        ctl.set_cc  = 1'b0;
        ctl.is_cond = 1'b0;

        case (icode)
            OP_STOP: begin
                ctl.st  = ST_STOP;
                ctl.len = LEN_W'(1);
            end
            OP_NOP: begin
                ctl.st  = ST_RUN;
                ctl.len = LEN_W'(1);
            end
            OP_MOVE: begin
                if (ifun <= CC_GT) begin
                    ctl.st      = ST_RUN;
                    ctl.len     = LEN_W'(2);
                    ctl.src_a   = opa;
                    ctl.dst_e   = opb;
                    ctl.is_cond = (ifun != CC_ALW);
                end
            end
            OP_IMM: begin
                ctl.st    = ST_RUN;
                ctl.len   = LEN_W'(FETCH_BYTES);
                ctl.dst_m = opb;
            end
            OP_ALU: begin
                if (ifun <= FN_XOR) begin
                    ctl.st     = ST_RUN;
                    ctl.len    = LEN_W'(2);
                    ctl.src_a  = opa;
                    ctl.src_b  = opb;
                    ctl.dst_e  = opb;
                    ctl.set_cc = 1'b1;
                end
            end
            default: ctl.st = ST_ILL;
        endcase
    end
endmodule

// File: rtl/bcc_exec.sv
module bcc_exec
    import bcc_pkg::*;
(
    input  logic [3:0]        icode,
    input  logic [3:0]        ifun,
    input  logic [WORD_W-1:0] rval_a,
    input  logic [WORD_W-1:0] rval_b,
    input  flags_t            flags_q,
    output logic [WORD_W-1:0] val_e,
    output flags_t            flags_res,
    output logic              cond_ok
);
    logic [WORD_W-1:0] alu_out;

    always_comb begin
        case (ifun)
            FN_ADD:  alu_out = rval_b + rval_a;
            FN_SUB:  alu_out = rval_b - rval_a;
            FN_AND:  alu_out = rval_b & rval_a;
            FN_XOR:  alu_out = rval_b ^ rval_a;
            default: alu_out = '0;
        endcase

        val_e = (icode == OP_ALU) ? alu_out : rval_a;

        flags_res.lt = alu_out[WORD_W-1];
        flags_res.eq = (alu_out == '0);
        flags_res.gt = !alu_out[WORD_W-1] && (alu_out != '0);

        case (ifun)
            CC_ALW:  cond_ok = 1'b1;
            CC_LE:   cond_ok = flags_q.lt || flags_q.eq;
            CC_LT:   cond_ok = flags_q.lt;
            CC_EQ:   cond_ok = flags_q.eq;
            CC_NE:   cond_ok = !flags_q.eq;
            CC_GE:   cond_ok = flags_q.gt || flags_q.eq;
            CC_GT:   cond_ok = flags_q.gt;
            default: cond_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcc_regfile.sv
module bcc_regfile
    import bcc_pkg::*;
#(
    parameter int NREGS = REG_CNT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_a_idx,
    input  logic [IDX_W-1:0]        rd_b_idx,
    output logic [WORD_W-1:0]       rd_a_val,
    output logic [WORD_W-1:0]       rd_b_val,
    input  logic [IDX_W-1:0]        wr_e_idx,
    input  logic [WORD_W-1:0]       wr_e_val,
    input  logic [IDX_W-1:0]        wr_m_idx,
    input  logic [WORD_W-1:0]       wr_m_val,
    output logic [NREGS*WORD_W-1:0] regs_flat
);
    localparam int AW = $clog2(NREGS);

    logic [WORD_W-1:0] regs_q [NREGS];
    logic [WORD_W-1:0] regs_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_e_idx == IDX_W'(i)) regs_d[i] = wr_e_val;
            if (wr_m_idx == IDX_W'(i)) regs_d[i] = wr_m_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd_a_val = (int'(rd_a_idx) < NREGS) ? regs_q[rd_a_idx[AW-1:0]] : '0;
    assign rd_b_val = (int'(rd_b_idx) < NREGS) ? regs_q[rd_b_idx[AW-1:0]] : '0;

    for (genvar g = 0; g < NREGS; g++) begin : g_flat
        assign regs_flat[g*WORD_W +: WORD_W] = regs_q[g];
    end
endmodule

// File: rtl/bcc_core.sv
module bcc_core
    import bcc_pkg::*;
#(
    parameter int NREGS = REG_CNT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [WORD_W-1:0]       imem_addr,
    input  logic [FETCH_W-1:0]      imem_data,
    output logic [1:0]              stat,
    output logic [NREGS*WORD_W-1:0] dbg_regs
);
    typedef struct packed {
        logic [WORD_W-1:0] pc;
        status_e           st;
        flags_t            cc;
    } core_state_t;

    core_state_t s_q, s_d;

    logic [3:0]        icode;
    logic [3:0]        ifun;
    logic [WORD_W-1:0] imm;
    ctrl_t             ctl;
    logic [WORD_W-1:0] rval_a;
    logic [WORD_W-1:0] rval_b;
    logic [WORD_W-1:0] val_e;
    flags_t            flags_res;
    logic              cond_ok;
    logic [IDX_W-1:0]  dst_e_d;
    logic [IDX_W-1:0]  dst_m_d;

    bcc_decode i_decode (
        .fetch_word (imem_data),
        .icode      (icode),
        .ifun       (ifun),
        .imm        (imm),
        .ctl        (ctl)
    );

    bcc_regfile #(.NREGS(NREGS)) i_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (ctl.src_a),
        .rd_b_idx  (ctl.src_b),
        .rd_a_val  (rval_a),
        .rd_b_val  (rval_b),
        .wr_e_idx  (dst_e_d),
        .wr_e_val  (val_e),
        .wr_m_idx  (dst_m_d),
        .wr_m_val  (imm),
        .regs_flat (dbg_regs)
    );

    bcc_exec i_exec (
        .icode     (icode),
        .ifun      (ifun),
        .rval_a    (rval_a),
        .rval_b    (rval_b),
        .flags_q   (s_q.cc),
        .val_e     (val_e),
        .flags_res (flags_res),
        .cond_ok   (cond_ok)
    );

    always_comb begin
        s_d     = s_q;
        dst_e_d = NO_REG;
        dst_m_d = NO_REG;
        if (s_q.st == ST_RUN) begin
            if (ctl.st != ST_RUN) begin
                s_d.st = ctl.st;
            end else begin
                s_d.pc  = s_q.pc + WORD_W'(ctl.len);
                if (ctl.set_cc) s_d.cc = flags_res;
                dst_e_d = (ctl.is_cond && !cond_ok) ? NO_REG : ctl.dst_e;
                dst_m_d = ctl.dst_m;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pc: '0, st: ST_RUN, cc: '{lt: 1'b0, eq: 1'b1, gt: 1'b0}};
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr = s_q.pc;
    assign stat      = s_q.st;
endmodule

// File: rtl/bcc_core_chk.sv
module bcc_core_chk
    import bcc_pkg::*;
#(
    parameter int NREGS = REG_CNT
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [WORD_W-1:0]       imem_addr,
    input logic [15:0]             fetch_lo,
    input logic [1:0]              stat,
    input logic [NREGS*WORD_W-1:0] dbg_regs
);
    logic [3:0] c_op;
    logic [3:0] c_fn;
    logic [3:0] c_rb;
    logic       c_run;
    logic       c_bad;

    assign c_op  = fetch_lo[7:4];
    assign c_fn  = fetch_lo[3:0];
    assign c_rb  = fetch_lo[11:8];
    assign c_run = (stat == 2'd0);
    assign c_bad = (c_op == 4'h4) || (c_op == 4'h5) || (c_op > 4'h6) ||
                   (c_op == OP_MOVE && c_fn > CC_GT) ||
                   (c_op == OP_ALU && c_fn > FN_XOR);

    a_r2_imm_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_run && c_op == OP_IMM) |=> (imem_addr == $past(imem_addr) + 32'd6));

    a_r3_move_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_run && c_op == OP_MOVE && c_fn <= CC_GT) |=> (imem_addr == $past(imem_addr) + 32'd2));

    a_r4_alu_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_run && c_op == OP_ALU && c_fn <= FN_XOR) |=>
            (imem_addr == $past(imem_addr) + 32'd2 && stat == 2'd0));

    a_r7_nop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_run && c_op == OP_NOP) |=>
            (imem_addr == $past(imem_addr) + 32'd1 && $stable(dbg_regs)));

    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (c_run && c_op == OP_STOP) |=>
            (stat == 2'd1 && $stable(imem_addr) && $stable(dbg_regs)));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_run) |=> ($stable(stat) && $stable(imem_addr) && $stable(dbg_regs)));

    a_r9_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (c_run && c_bad) |=> (stat == 2'd2 && $stable(imem_addr) && $stable(dbg_regs)));

    a_r10_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (c_run && c_op == OP_IMM && c_rb == NO_REG) |=> $stable(dbg_regs));
endmodule

bind bcc_core bcc_core_chk #(.NREGS(NREGS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .fetch_lo  (imem_data[15:0]),
    .stat      (stat),
    .dbg_regs  (dbg_regs)
);

// File: tb/test_bcc_core.sv
`timescale 1ns/1ps
module test_bcc_core;
    localparam int NR = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [31:0]    imem_addr;
    logic [47:0]    imem_data;
    logic [1:0]     stat;
    logic [NR*32-1:0] dbg_regs;

    logic [7:0]  mem [256];
    logic [7:0]  fa;
    int          n_chk = 0;
    int          n_err = 0;
    int          wp = 0;

    logic [31:0] m_r [NR];
    logic [31:0] m_pc;
    logic [1:0]  m_st;
    logic        m_lt, m_eq, m_gt;

    always #2.5 clk = ~clk;

    assign fa = imem_addr[7:0];
    assign imem_data = {mem[8'(fa + 8'd5)], mem[8'(fa + 8'd4)], mem[8'(fa + 8'd3)],
                        mem[8'(fa + 8'd2)], mem[8'(fa + 8'd1)], mem[fa]};

    bcc_core i_bcc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .stat      (stat),
        .dbg_regs  (dbg_regs)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dut_reg(input int i);
        return dbg_regs[32*i +: 32];
    endfunction

    // ---------------- program building ----------------
    task automatic emit(input logic [7:0] b);
        mem[wp[7:0]] = b;
        wp++;
    endtask
    task automatic e_imm(input logic [3:0] rb, input logic [31:0] v);
        emit(8'h30); emit({4'hF, rb});
        emit(v[7:0]); emit(v[15:8]); emit(v[23:16]); emit(v[31:24]);
    endtask
    task automatic e_mov(input logic [3:0] fn, input logic [3:0] ra, input logic [3:0] rb);
        emit({4'h2, fn}); emit({ra, rb});
    endtask
    task automatic e_alu(input logic [3:0] fn, input logic [3:0] ra, input logic [3:0] rb);
        emit({4'h6, fn}); emit({ra, rb});
    endtask

    task automatic begin_prog();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wp = 0;
    endtask

    // ---------------- reference model ----------------
    function automatic logic [31:0] m_rd(input logic [3:0] i);
        return (i < 4'd8) ? m_r[i[2:0]] : 32'd0;
    endfunction

    function automatic logic m_cond(input logic [3:0] fn);
        case (fn)
            4'd0: return 1'b1;
            4'd1: return !m_gt;
            4'd2: return m_lt;
            4'd3: return m_eq;
            4'd4: return !m_eq;
            4'd5: return !m_lt;
            default: return m_gt;
        endcase
    endfunction

    task automatic model_step(output string tag);
        logic [47:0] w;
        logic [3:0]  ic, fn, ra, rb;
        logic [31:0] a, b, res;
        if (m_st != 2'd0) begin
            tag = (m_st == 2'd1) ? "R8" : "R9";
            return;
        end
        for (int k = 0; k < 6; k++) w[8*k +: 8] = mem[8'(m_pc[7:0] + 8'(k))];
        ic = w[7:4]; fn = w[3:0]; ra = w[15:12]; rb = w[11:8];
        case (ic)
            4'h0: begin m_st = 2'd1; tag = "R8"; end
            4'h1: begin m_pc += 32'd1; tag = "R7"; end
            4'h2: begin
                if (fn > 4'd6) begin m_st = 2'd2; tag = "R9"; end
                else begin
                    if (m_cond(fn) && rb < 4'd8) m_r[rb[2:0]] = m_rd(ra);
                    m_pc += 32'd2;
                    tag = (fn == 4'd0) ? "R3" : "R6";
                end
            end
            4'h3: begin
                if (rb < 4'd8) m_r[rb[2:0]] = w[47:16];
                m_pc += 32'd6;
                tag = "R2";
            end
            4'h6: begin
                if (fn > 4'd3) begin m_st = 2'd2; tag = "R9"; end
                else begin
                    a = m_rd(ra); b = m_rd(rb);
                    case (fn)
                        4'd0: res = b + a;
                        4'd1: res = b - a;
                        4'd2: res = b & a;
                        default: res = b ^ a;
                    endcase
                    m_lt = $signed(res) < 0;
                    m_eq = (res == 32'd0);
                    m_gt = $signed(res) > 0;
                    if (rb < 4'd8) m_r[rb[2:0]] = res;
                    m_pc += 32'd2;
                    tag = "R4";
                end
            end
            default: begin m_st = 2'd2; tag = "R9"; end
        endcase
    endtask

    task automatic compare_all(input string tag);
        check(tag, "pc", imem_addr, m_pc);
        check(tag, "stat", {30'd0, stat}, {30'd0, m_st});
        for (int i = 0; i < NR; i++) check(tag, $sformatf("reg%0d", i), dut_reg(i), m_r[i]);
    endtask

    task automatic run_prog(input int maxc);
        string tag;
        int    extra;
        extra = 0;
        for (int i = 0; i < NR; i++) m_r[i] = 32'd0;
        m_pc = 32'd0; m_st = 2'd0; m_lt = 1'b0; m_eq = 1'b1; m_gt = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");
        for (int c = 0; c < maxc; c++) begin
            @(posedge clk);
            @(negedge clk);
            model_step(tag);
            compare_all(tag);
            if (m_st != 2'd0) begin
                extra++;
                if (extra == 3) break;
            end
        end
    endtask

    function automatic logic [3:0] rnd_reg();
        if ($urandom % 16 == 0) return 4'hF;
        return 4'($urandom % 8);
    endfunction

    function automatic logic [31:0] rnd_imm();
        case ($urandom % 6)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int unsigned seed;
        logic [7:0] bad [4];
        seed = $urandom(32'd20240611);
        bad[0] = 8'h67; bad[1] = 8'h27; bad[2] = 8'h40; bad[3] = 8'hC0;

        // R2: worked example window 0x0000000af230
        begin_prog();
        emit(8'h30); emit(8'hf2); emit(8'h0a); emit(8'h00); emit(8'h00); emit(8'h00);
        run_prog(20);
        check("R2", "example dest reg2", dut_reg(2), 32'd10);
        check("R8", "pc held on stop", imem_addr, 32'd6);
        check("R8", "stopped status", {30'd0, stat}, 32'd1);

        // R5 / R11: reset flags, flags kept across non-ALU operations
        begin_prog();
        e_imm(4'd3, 32'd5);
        e_mov(4'd3, 4'd3, 4'd1);
        e_mov(4'd4, 4'd3, 4'd2);
        e_imm(4'd4, 32'd1);
        e_alu(4'd1, 4'd4, 4'd0);
        e_mov(4'd0, 4'd0, 4'd5);
        e_mov(4'd2, 4'd4, 4'd6);
        e_mov(4'd6, 4'd4, 4'd7);
        run_prog(30);
        check("R5", "eq after reset moves", dut_reg(1), 32'd5);
        check("R6", "ne after reset discarded", dut_reg(2), 32'd0);
        check("R4", "sub result", dut_reg(0), 32'hFFFF_FFFF);
        check("R11", "lt kept over move", dut_reg(6), 32'd1);
        check("R6", "gt false discarded", dut_reg(7), 32'd0);

        // R5: signed overflow to 0x80000000 counts as negative
        begin_prog();
        e_imm(4'd1, 32'h7FFF_FFFF);
        e_imm(4'd2, 32'd1);
        e_alu(4'd0, 4'd2, 4'd1);
        e_mov(4'd2, 4'd2, 4'd3);
        e_mov(4'd6, 4'd2, 4'd4);
        run_prog(30);
        check("R4", "add wraps", dut_reg(1), 32'h8000_0000);
        check("R5", "lt after overflow", dut_reg(3), 32'd1);
        check("R5", "gt clear after overflow", dut_reg(4), 32'd0);

        // R10: index 0xF reads zero, writes discarded
        begin_prog();
        e_imm(4'd1, 32'd7);
        e_imm(4'hF, 32'h0000_1234);
        e_mov(4'd0, 4'hF, 4'd1);
        run_prog(20);
        check("R10", "all regs zero", {31'd0, dbg_regs == '0}, 32'd1);

        // R7: no-op length
        begin_prog();
        e_imm(4'd1, 32'd3);
        emit(8'h10); emit(8'h10);
        run_prog(20);
        check("R7", "pc after two no-ops", imem_addr, 32'd8);
        check("R7", "reg1 untouched", dut_reg(1), 32'd3);

        // R9: illegal forms
        for (int b = 0; b < 4; b++) begin
            begin_prog();
            e_imm(4'd1, 32'd9);
            emit(bad[b]); emit(8'h12);
            run_prog(20);
            check("R9", $sformatf("status for %h", bad[b]), {30'd0, stat}, 32'd2);
            check("R9", $sformatf("pc for %h", bad[b]), imem_addr, 32'd6);
            check("R9", $sformatf("reg1 for %h", bad[b]), dut_reg(1), 32'd9);
        end

        // random programs
        for (int p = 0; p < 60; p++) begin
            int n;
            begin_prog();
            n = 5 + int'($urandom % 26);
            for (int k = 0; k < n; k++) begin
                case ($urandom % 10)
                    0, 1, 2, 9: e_imm(rnd_reg(), rnd_imm());
                    3, 4, 8:    e_alu(4'($urandom % 4), rnd_reg(), rnd_reg());
                    5, 6:       e_mov(4'($urandom % 7), rnd_reg(), rnd_reg());
                    default:    emit(8'h10);
                endcase
            end
            if ($urandom % 8 == 0) emit(bad[$urandom % 4]);
            else emit(8'h00);
            run_prog(n + 10);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule